// File: doc/BRIEF.md
# Byte Read-Modify-Write Logic Sequencer

This block carries out the byte-wide logic instructions that work directly on memory. When an instruction is accepted, the block takes a snapshot of the operands. It reads one byte and combines it with an 8-bit immediate using AND, OR or XOR. It then writes the result back to the same byte address. A test-only form makes the same comparison, reports the zero flag (T) and skips the write. A test-and-set form reads the byte at the address held in a general register. It reports whether that byte was zero, then writes it back with its top bit set. While that form runs, the block holds a lock output so that nothing can come between the read and the write.

The block sits beside the main execution unit. It is given the 16-bit instruction word, R0, the global base register and Rn, with a one-cycle `start`. It drives a simple synchronous byte port that has a read strobe, a write strobe and a `mem_ready` handshake. When it finishes it returns a one-cycle `done`, together with a T write-enable and the new T value.

Top module: `brmw_seq`

## Requirements
- R1: The instruction's upper byte selects the operation: 0xCD is AND, 0xCF is OR, 0xCE is XOR and 0xCC is TEST, each applied to the immediate in bits 7:0. Test-and-set is bits 15:12 = 0x4 with bits 7:0 = 0x1B. A `start` with any other word causes no memory access and no `done`.
- R2: The byte address is captured when the instruction is accepted. For the four immediate forms it is the 32-bit sum R0 + GBR, modulo 2^32. For test-and-set it is Rn. Changes on R0, GBR or Rn after acceptance have no effect.
- R3: AND, OR and XOR write the combined byte back to the address that was read, and they leave `t_we` low.
- R4: TEST performs no write. It asserts `t_we` with `done`, and `t_val` is 1 exactly when (byte & immediate) is zero.
- R5: Test-and-set asserts `t_we` with `done`, and `t_val` is 1 exactly when the byte it read was zero. It writes that byte back with bit 7 forced to 1.
- R6: With `mem_ready` always high, `done` is asserted 3 cycles after the accepting cycle for the four immediate forms and 4 cycles after it for test-and-set.
- R7: A read or write strobe stays asserted, with a stable address (and stable write data), until a cycle in which `mem_ready` is high. Each wait cycle delays `done` by one cycle. The two strobes are never high together.
- R8: `mem_lock` is high from the first read cycle of a test-and-set through the cycle in which its write completes. It is low at all other times and for every other operation.
- R9: `start` is ignored while an operation is in progress.
- R10: `done` lasts exactly one cycle, and `t_we` is high only together with `done`.
- R11: After reset the block is idle, with all strobes, `mem_lock`, `done` and `t_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction offered this cycle |
| instr | input | 16 | Instruction word |
| r0 | input | 32 | Index register R0 |
| gbr | input | 32 | Global base register |
| rn | input | 32 | Address register for test-and-set |
| mem_rdata | input | 8 | Read data from the byte port |
| mem_ready | input | 1 | Current strobe completes this cycle |
| mem_addr | output | 32 | Byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_lock | output | 1 | Bus held for indivisible test-and-set |
| done | output | 1 | Operation finished (one cycle) |
| t_we | output | 1 | T flag update enable |
| t_val | output | 1 | New T flag value |

## Verification
The hardest behaviour to reach from the ports is a new `start` that arrives while an operation is still busy, combined with operand registers that change under a stalled strobe. The stimulus for this drives a second, valid instruction and scrambled register values in the middle of an operation. It also holds `mem_ready` low for several cycles on both the read and the write of a test-and-set. The bench's cycle model then shows that the address, the write data, the lock window and the moment of `done` all stay tied to the first instruction.

// File: rtl/brmw_pkg.sv
package brmw_pkg;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_AND  = 3'd1,
      OP_OR   = 3'd2,
      OP_XOR  = 3'd3,
      OP_TST  = 3'd4,
      OP_TAS  = 3'd5
   } brmw_op_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_READ   = 3'd1,
      ST_MODIFY = 3'd2,
      ST_WRITE  = 3'd3,
      ST_DONE   = 3'd4
   } brmw_state_e;

   localparam logic [7:0] HI_TST = 8'hCC;
   localparam logic [7:0] HI_AND = 8'hCD;
   localparam logic [7:0] HI_XOR = 8'hCE;
   localparam logic [7:0] HI_OR  = 8'hCF;
   localparam logic [3:0] TAS_TOP = 4'h4;
   localparam logic [7:0] TAS_LOW = 8'h1B;

endpackage

// File: rtl/brmw_decode.sv
module brmw_decode
   import brmw_pkg::*;
#(
   parameter int INSTR_W = 16
) (
   input  logic [INSTR_W-1:0] instr,
   output brmw_op_e           op
);

   localparam int HI_LSB = INSTR_W - 8;
   localparam int TOP_LSB = INSTR_W - 4;

   logic [7:0] hi_byte;
   logic [3:0] top_nib;
   logic [7:0] lo_byte;

   assign hi_byte = instr[INSTR_W-1:HI_LSB];
   assign top_nib = instr[INSTR_W-1:TOP_LSB];
   assign lo_byte = instr[7:0];

   always_comb begin
      op = OP_NONE;
      unique case (hi_byte)
         HI_AND:  op = OP_AND;
         HI_OR:   op = OP_OR;
         HI_XOR:  op = OP_XOR;
         HI_TST:  op = OP_TST;
         default: op = OP_NONE;
      endcase
      if (top_nib == TAS_TOP && lo_byte == TAS_LOW) begin
         op = OP_TAS;
      end
   end

endmodule

// File: rtl/brmw_alu.sv
module brmw_alu
   import brmw_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int TAS_BIT = DATA_W - 1
) (
   input  brmw_op_e          op,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] imm,
   output logic [DATA_W-1:0] result,
   output logic              t_flag
);

   logic sel_and, sel_or, sel_xor, sel_tas;

   assign sel_and = (op == OP_AND);
   assign sel_or  = (op == OP_OR);
   assign sel_xor = (op == OP_XOR);
   assign sel_tas = (op == OP_TAS);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam bit IS_SET_BIT = (b == TAS_BIT);
      logic set_here;
      assign set_here = sel_tas & IS_SET_BIT;
      assign result[b] = sel_and  ? (operand[b] & imm[b]) :
                         sel_or   ? (operand[b] | imm[b]) :
                         sel_xor  ? (operand[b] ^ imm[b]) :
                         set_here ? 1'b1 : operand[b];
   end

   always_comb begin
      unique case (op)
         OP_TST:  t_flag = ~|(operand & imm);
         OP_TAS:  t_flag = ~|operand;
         default: t_flag = 1'b0;
      endcase
   end

endmodule

// File: rtl/brmw_fsm.sv
module brmw_fsm
   import brmw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_ok,
   input  logic is_tst,
   input  logic is_tas,
   input  logic mem_ready,
   output logic accept,
   output logic rd_cap,
   output logic mod_en,
   output logic rd,
   output logic wr,
   output logic lock,
   output logic done
);

   brmw_state_e st, st_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nxt;
   end

   always_comb begin
      st_nxt = st;
      unique case (st)
         ST_IDLE:   if (start_ok) st_nxt = ST_READ;
         ST_READ:   if (mem_ready) st_nxt = ST_MODIFY;
         ST_MODIFY: st_nxt = is_tst ? ST_DONE : ST_WRITE;
         ST_WRITE:  if (mem_ready) st_nxt = is_tas ? ST_DONE : ST_IDLE;
         ST_DONE:   st_nxt = ST_IDLE;
         default:   st_nxt = ST_IDLE;
      endcase
   end

   assign accept = (st == ST_IDLE) && start_ok;
   assign rd     = (st == ST_READ);
   assign wr     = (st == ST_WRITE);
   assign rd_cap = rd && mem_ready;
   assign mod_en = (st == ST_MODIFY);
   assign lock   = is_tas && (rd || mod_en || wr);
   assign done   = (wr && mem_ready && !is_tas) || (st == ST_DONE);

endmodule

// File: rtl/brmw_seq.sv
module brmw_seq
   import brmw_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 8,
   parameter int INSTR_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  r0,
   input  logic [ADDR_W-1:0]  gbr,
   input  logic [ADDR_W-1:0]  rn,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic               mem_ready,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               mem_lock,
   output logic               done,
   output logic               t_we,
   output logic               t_val
);

   localparam int TAS_BIT = DATA_W - 1;

   if (INSTR_W != 16) begin : g_bad_instr
      $error("brmw_seq: INSTR_W must be 16");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("brmw_seq: DATA_W must be 8 to match the immediate field");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("brmw_seq: ADDR_W must be at least 8");
   end

   brmw_op_e          op_dec, op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] imm_q, rdata_q, wdata_q, alu_res;
   logic              t_q, alu_t;
   logic              accept, rd_cap, mod_en, done_i;

   brmw_decode #(.INSTR_W(INSTR_W)) u_dec (
      .instr (instr),
      .op    (op_dec)
   );

   brmw_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_ok  (start && (op_dec != OP_NONE)),
      .is_tst    (op_q == OP_TST),
      .is_tas    (op_q == OP_TAS),
      .mem_ready (mem_ready),
      .accept    (accept),
      .rd_cap    (rd_cap),
      .mod_en    (mod_en),
      .rd        (mem_rd),
      .wr        (mem_wr),
      .lock      (mem_lock),
      .done      (done_i)
   );

   brmw_alu #(.DATA_W(DATA_W), .TAS_BIT(TAS_BIT)) u_alu (
      .op      (op_q),
      .operand (rdata_q),
      .imm     (imm_q),
      .result  (alu_res),
      .t_flag  (alu_t)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= OP_NONE;
         addr_q  <= '0;
         imm_q   <= '0;
         rdata_q <= '0;
         wdata_q <= '0;
         t_q     <= 1'b0;
      end else begin
         if (accept) begin
            op_q   <= op_dec;
            imm_q  <= instr[DATA_W-1:0];
            addr_q <= (op_dec == OP_TAS) ? rn : (r0 + gbr);
         end
         if (rd_cap) rdata_q <= mem_rdata;
         if (mod_en) begin
            wdata_q <= alu_res;
            t_q     <= alu_t;
         end
      end
   end

   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign done      = done_i;
   assign t_we      = done_i && ((op_q == OP_TST) || (op_q == OP_TAS));
   assign t_val     = t_we && t_q;

endmodule

// File: rtl/brmw_seq_chk.sv
module brmw_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_lock,
   input logic              done,
   input logic              t_we
);

   // R7
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && !mem_ready |=> mem_rd && $stable(mem_addr));

   // R7
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr && !mem_ready |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R3
   same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr) |-> $stable(mem_addr));

   // R8
   lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_lock && mem_rd |=> mem_lock);

   // R8
   lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_lock && mem_wr && mem_ready |=> !mem_lock);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   twe_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_we |-> done);

endmodule

bind brmw_seq brmw_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_wdata (mem_wdata),
   .mem_lock  (mem_lock),
   .done      (done),
   .t_we      (t_we)
);

// File: tb/brmw_seq_bench.sv
`timescale 1ns/1ps
module brmw_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0;
   logic [31:0] r0 = '0, gbr = '0, rn = '0;
   logic [7:0]  mem_rdata;
   logic        mem_ready = 1'b1;
   logic [31:0] mem_addr;
   logic        mem_rd, mem_wr, mem_lock, done, t_we, t_val;
   logic [7:0]  mem_wdata;

   logic [7:0]  mem [0:255];
   int          checks = 0;
   int          errors = 0;
   int          cycles = 0;

   always #4 clk = ~clk;

   brmw_seq u_brmw_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .r0(r0), .gbr(gbr), .rn(rn), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_lock(mem_lock), .done(done), .t_we(t_we), .t_val(t_val)
   );

   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_wr && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // 0 none, 1 and, 2 or, 3 xor, 4 test, 5 test-and-set
   function automatic int kind_of(input logic [15:0] w);
      if (w[15:12] == 4'h4 && w[7:0] == 8'h1B) return 5;
      case (w[15:8])
         8'hCD: return 1;
         8'hCF: return 2;
         8'hCE: return 3;
         8'hCC: return 4;
         default: return 0;
      endcase
   endfunction

   task automatic run_op(input logic [15:0] w, input logic [31:0] a0, input logic [31:0] ag,
                         input logic [31:0] an, input int rw, input int ww, input bit poke);
      int k = kind_of(w);
      bit has_wr = (k != 4);
      bit tas = (k == 5);
      logic [31:0] ea = tas ? an : a0 + ag;
      logic [7:0] pre = mem[ea[7:0]];
      logic [7:0] imm = w[7:0];
      logic [7:0] res;
      bit exp_t;
      int last;
      case (k)
         1: res = pre & imm;
         2: res = pre | imm;
         3: res = pre ^ imm;
         5: res = pre | 8'h80;
         default: res = pre;
      endcase
      exp_t = (k == 4) ? ((pre & imm) == 0) : (pre == 0);
      last = (k == 4) ? rw + 3 : (tas ? rw + ww + 4 : rw + ww + 3);
      @(negedge clk);
      start = 1'b1; instr = w; r0 = a0; gbr = ag; rn = an; mem_ready = 1'b1;
      for (int c = 1; c <= last + 1; c++) begin
         bit e_rd, e_wr, e_lock, e_done;
         @(negedge clk);
         if (c == 1) start = 1'b0;
         if (poke && c == 2) begin
            start = 1'b1; instr = 16'hCF01; r0 = 32'h0000_00A0; gbr = 32'h11; rn = 32'h99;
         end
         if (poke && c == 3) start = 1'b0;
         e_rd   = (c <= rw + 1);
         e_wr   = has_wr && c >= rw + 3 && c <= rw + ww + 3;
         e_lock = tas && c <= rw + ww + 3;
         e_done = (c == last);
         mem_ready = !((c <= rw) || (e_wr && c < rw + ww + 3));
         #1;
         chk(mem_rd == e_rd, "R7", "read strobe", mem_rd, e_rd);
         chk(mem_wr == e_wr, k == 4 ? "R4" : "R7", "write strobe", mem_wr, e_wr);
         chk(mem_lock == e_lock, "R8", "lock", mem_lock, e_lock);
         chk(done == e_done, c == last + 1 ? "R10" : "R6", "done", done, e_done);
         chk(t_we == (e_done && (k >= 4)), "R10", "t_we", t_we, e_done && (k >= 4));
         if (e_done && k >= 4) chk(t_val == exp_t, tas ? "R5" : "R4", "t_val", t_val, exp_t);
         if (e_rd || e_wr) chk(mem_addr == ea, poke ? "R9" : "R2", "address", mem_addr, ea);
         if (e_wr) chk(mem_wdata == res, tas ? "R5" : "R3", "write data", mem_wdata, res);
      end
      mem_ready = 1'b1;
      chk(mem[ea[7:0]] == res, has_wr ? "R3" : "R4", "memory byte", mem[ea[7:0]], res);
   endtask

   task automatic reject(input logic [15:0] w);
      @(negedge clk);
      start = 1'b1; instr = w;
      for (int c = 1; c <= 4; c++) begin
         @(negedge clk);
         start = 1'b0;
         #1;
         chk(!mem_rd && !mem_wr && !done, "R1", "unsupported word", {mem_rd, mem_wr, done}, 0);
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 29 + 3);
      mem[8'h30] = 8'h5A; mem[8'h15] = 8'h41; mem[8'h60] = 8'h3C;
      mem[8'h70] = 8'hF0; mem[8'h71] = 8'h12; mem[8'h42] = 8'h00;
      mem[8'h43] = 8'h05; mem[8'h44] = 8'h00;
      repeat (3) @(negedge clk);
      #1;
      // R11 reset state
      chk(!mem_rd && !mem_wr && !mem_lock && !done && !t_we, "R11", "reset outputs",
          {mem_rd, mem_wr, mem_lock, done, t_we}, 0);
      rst_n = 1'b1;
      run_op(16'hCD0F, 32'h10, 32'h20, 32'h0, 0, 0, 0);          // AND
      run_op(16'hCF81, 32'hFFFF_FFF0, 32'h25, 32'h0, 2, 1, 0);   // OR, address wraps
      run_op(16'hCEFF, 32'h40, 32'h20, 32'h0, 0, 0, 1);          // XOR, busy start
      run_op(16'hCC0F, 32'h70, 32'h0, 32'h0, 0, 0, 0);           // TEST zero
      run_op(16'hCC02, 32'h61, 32'h10, 32'h0, 1, 0, 0);          // TEST nonzero
      run_op(16'h421B, 32'h0, 32'h0, 32'h42, 0, 0, 0);           // TAS zero
      run_op(16'h4D1B, 32'h7, 32'h9, 32'hABCD_0043, 1, 2, 1);    // TAS nonzero, waits
      run_op(16'h401B, 32'h0, 32'h0, 32'h44, 3, 3, 0);           // TAS with long waits
      reject(16'h2009);
      reject(16'hC809);
      reject(16'h401A);
      run_op(16'hCD0F, 32'h10, 32'h20, 32'h0, 0, 0, 0);          // after rejects
      summary();
   end

endmodule